// File: doc/BRIEF.md
# Sized Logical Operation Unit

This unit is the bitwise datapath of a processor that works on byte, word and long operands. It applies AND, OR, exclusive-OR or complement to a destination value and a source value. It writes the result back into the destination register image at the requested width and leaves the bits above that width untouched. It also produces the negative and zero condition flags, clears overflow and carry, and passes the extend flag through unchanged.

Alongside the data it reports the cycle cost of the form that was executed, and how far the program counter moves past the immediate extension words. The cost depends on four things: the operand width, whether the destination is a register or memory, whether the source is an immediate, and which operation was selected. For memory destinations the caller supplies an addressing-mode penalty, and the unit adds it to the cost. Opcode decode, address generation and bus traffic are handled elsewhere. The caller presents one operation per cycle with `in_valid`, and the results are registered one clock later.

Top module: `sized_logic_unit`

## Requirements
- R1: `op_sel` picks the operation: 0 = AND, 1 = OR, 2 = exclusive-OR, 3 = complement of `dest_old`. The low bits of `out_value` hold the sized result one cycle after `in_valid`. The width is 8 bits for `size_code` 0, 16 bits for 1 and 32 bits for 2. `out_valid` follows `in_valid` by one cycle.
- R2: `out_n` equals the top bit of the sized result (bit 7, 15 or 31). `out_z` is 1 exactly when every bit of the sized result is 0.
- R3: Every legal operation drives `out_v` and `out_c` to 0.
- R4: A form with no immediate source costs 4 cycles for byte or word and 8 for long when the destination is a register. When the destination is memory it costs 8 for byte or word and 12 for long, plus `ea_penalty`.
- R5: For byte size, `out_value[31:8]` equals `dest_old[31:8]`. For word size, `out_value[31:16]` equals `dest_old[31:16]`.
- R6: An immediate AND costs 8 cycles with a register destination and 12 plus `ea_penalty` with a memory destination, at every size. An immediate OR or exclusive-OR of long size costs 16, or 20 plus `ea_penalty` for memory. At byte or word size these cost 8, or 12 plus `ea_penalty` for memory.
- R7: `out_pc_step` is 2 for an immediate form of byte or word size and 4 for one of long size. It is 0 when the source is not an immediate. A byte immediate uses only bits 7:0 of `src_val`.
- R8: `size_code` 3 raises `out_illegal`. In that case `out_value` equals `dest_old`, the N, Z, V and C flag outputs keep their previous values, and `out_cycles` and `out_pc_step` are 0.
- R9: `out_x` equals `flag_x_in` from the accepted operation, whether the operation is legal or not.
- R10: The complement operation ignores `src_val` and `src_is_imm`. It is costed as a form without an immediate (R4), and its `out_pc_step` is 0.
- R11: After reset, `out_valid`, `out_value`, all flag outputs, `out_cycles`, `out_pc_step` and `out_illegal` are 0. While `in_valid` is low, the outputs other than `out_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 2 | 0 AND, 1 OR, 2 exclusive-OR, 3 complement |
| size_code | input | 2 | 0 byte, 1 word, 2 long, 3 illegal |
| dst_is_mem | input | 1 | Destination is a memory operand |
| src_is_imm | input | 1 | Source comes from immediate extension words |
| dest_old | input | 32 | Current full destination value |
| src_val | input | 32 | Source data register value or immediate |
| ea_penalty | input | PEN_W | Addressing-mode cycle penalty for memory forms |
| flag_x_in | input | 1 | Incoming extend flag |
| out_valid | output | 1 | Results of the previous cycle's operation are valid |
| out_value | output | 32 | Merged destination value |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |
| out_x | output | 1 | Extend flag |
| out_cycles | output | CYC_W | Cycle cost of the executed form |
| out_pc_step | output | 3 | Program counter advance for immediate words |
| out_illegal | output | 1 | Illegal size code was presented |

## Verification
The sweep covers every operation, size, destination kind and source kind against operand pairs chosen to stress the edges. These include all-ones against all-zeros, sign bits placed exactly at bit 7, 15 and 31, and values whose non-zero bits lie only above the active width. A merge that spills into the upper bits, or a zero test that looks at all 32 bits, shows up as a wrong value or a wrong Z on those pairs. The cost checks separate immediate AND from immediate OR and exclusive-OR at long size, where a shared cost table would report 16 or 20 instead of 8 or 12. They also check that complement ignores the immediate flag. Illegal size codes are placed between legal operations that leave set flags behind, so a design that updates the flags or the value on size 3 fails.

// File: rtl/slu_pkg.sv
`timescale 1ns/1ps
package slu_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned LANES = DW / 8;

  typedef enum logic [1:0] {
    LOP_AND = 2'd0,
    LOP_OR  = 2'd1,
    LOP_XOR = 2'd2,
    LOP_NOT = 2'd3
  } lop_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } osize_e;

  // Number of byte lanes written for a size code.
  function automatic int unsigned lanes_of(logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_WORD: return 2;
      SZ_LONG: return 4;
      default: return 0;
    endcase
  endfunction

  // Sign bit of the sized result.
  function automatic logic sized_msb(logic [DW-1:0] v, logic [1:0] sz);
    case (sz)
      SZ_BYTE: return v[7];
      SZ_WORD: return v[15];
      default: return v[31];
    endcase
  endfunction

  // Fixed part of the cost, before the addressing penalty.
  function automatic logic [7:0] base_cost(logic [1:0] op, logic [1:0] sz,
                                           logic mem, logic imm);
    logic is_long;
    is_long = (sz == SZ_LONG);
    if (imm && op != LOP_NOT) begin
      if (op == LOP_AND)   return mem ? 8'd12 : 8'd8;
      else if (is_long)    return mem ? 8'd20 : 8'd16;
      else                 return mem ? 8'd12 : 8'd8;
    end
    if (is_long)           return mem ? 8'd12 : 8'd8;
    return mem ? 8'd8 : 8'd4;
  endfunction

  // Bytes of immediate extension words consumed.
  function automatic logic [2:0] imm_bytes(logic [1:0] sz);
    return (sz == SZ_LONG) ? 3'd4 : 3'd2;
  endfunction
endpackage

// File: rtl/slu_logic_core.sv
`timescale 1ns/1ps
module slu_logic_core
  import slu_pkg::*;
(
  input  logic [1:0]    op,
  input  logic [DW-1:0] dst,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] raw
);
  always_comb begin
    case (lop_e'(op))
      LOP_AND: raw = dst & src;
      LOP_OR:  raw = dst | src;
      LOP_XOR: raw = dst ^ src;
      default: raw = ~dst;
    endcase
  end
endmodule

// File: rtl/slu_merge.sv
`timescale 1ns/1ps
module slu_merge
  import slu_pkg::*;
(
  input  logic [1:0]    size,
  input  logic [DW-1:0] raw,
  input  logic [DW-1:0] dest,
  output logic [DW-1:0] merged,
  output logic          neg,
  output logic          zero
);
  logic [LANES-1:0] lane_wr;
  logic [DW-1:0]    sized;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_wr[g]          = (g < lanes_of(size));
      assign merged[g*8 +: 8]    = lane_wr[g] ? raw[g*8 +: 8] : dest[g*8 +: 8];
      assign sized[g*8 +: 8]     = lane_wr[g] ? raw[g*8 +: 8] : 8'h00;
    end
  endgenerate

  assign neg  = sized_msb(raw, size);
  assign zero = (sized == '0);
endmodule

// File: rtl/slu_cost.sv
`timescale 1ns/1ps
module slu_cost
  import slu_pkg::*;
#(
  parameter int unsigned CYC_W = 8,
  parameter int unsigned PEN_W = 6
) (
  input  logic [1:0]       op,
  input  logic [1:0]       size,
  input  logic             mem,
  input  logic             imm,
  input  logic [PEN_W-1:0] penalty,
  output logic [CYC_W-1:0] cycles,
  output logic [2:0]       pc_step,
  output logic             illegal
);
  logic       imm_form;
  logic [7:0] base;

  assign illegal  = (size == SZ_BAD);
  assign imm_form = imm && (op != LOP_NOT);
  assign base     = base_cost(op, size, mem, imm);
  assign cycles   = illegal ? '0
                  : CYC_W'(base) + (mem ? CYC_W'(penalty) : CYC_W'(0));
  assign pc_step  = (illegal || !imm_form) ? 3'd0 : imm_bytes(size);
endmodule

// File: rtl/sized_logic_unit.sv
`timescale 1ns/1ps
module sized_logic_unit
  import slu_pkg::*;
#(
  parameter int unsigned CYC_W = 8,
  parameter int unsigned PEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       op_sel,
  input  logic [1:0]       size_code,
  input  logic             dst_is_mem,
  input  logic             src_is_imm,
  input  logic [31:0]      dest_old,
  input  logic [31:0]      src_val,
  input  logic [PEN_W-1:0] ea_penalty,
  input  logic             flag_x_in,
  output logic             out_valid,
  output logic [31:0]      out_value,
  output logic             out_n,
  output logic             out_z,
  output logic             out_v,
  output logic             out_c,
  output logic             out_x,
  output logic [CYC_W-1:0] out_cycles,
  output logic [2:0]       out_pc_step,
  output logic             out_illegal
);
  logic [DW-1:0]    raw_res;
  logic [DW-1:0]    merged_res;
  logic             neg_flag, zero_flag;
  logic [CYC_W-1:0] cost_cyc;
  logic [2:0]       cost_pc;
  logic             bad_size;

  slu_logic_core u_core (
    .op  (op_sel),
    .dst (dest_old),
    .src (src_val),
    .raw (raw_res)
  );

  slu_merge u_merge (
    .size   (size_code),
    .raw    (raw_res),
    .dest   (dest_old),
    .merged (merged_res),
    .neg    (neg_flag),
    .zero   (zero_flag)
  );

  slu_cost #(.CYC_W(CYC_W), .PEN_W(PEN_W)) u_cost (
    .op      (op_sel),
    .size    (size_code),
    .mem     (dst_is_mem),
    .imm     (src_is_imm),
    .penalty (ea_penalty),
    .cycles  (cost_cyc),
    .pc_step (cost_pc),
    .illegal (bad_size)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_value   <= '0;
      out_n       <= 1'b0;
      out_z       <= 1'b0;
      out_v       <= 1'b0;
      out_c       <= 1'b0;
      out_x       <= 1'b0;
      out_cycles  <= '0;
      out_pc_step <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_x       <= flag_x_in;
        out_illegal <= bad_size;
        out_cycles  <= cost_cyc;
        out_pc_step <= cost_pc;
        if (bad_size) begin
          out_value <= dest_old;
        end else begin
          out_value <= merged_res;
          out_n     <= neg_flag;
          out_z     <= zero_flag;
          out_v     <= 1'b0;
          out_c     <= 1'b0;
        end
      end
    end
  end

  AST_X_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_x == $past(flag_x_in)); // R9

  AST_BYTE_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && size_code == SZ_BYTE |=> out_value[31:8] == $past(dest_old[31:8])); // R5

  AST_WORD_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && size_code == SZ_WORD |=> out_value[31:16] == $past(dest_old[31:16])); // R5

  AST_ILLEGAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && size_code == SZ_BAD |=>
      out_illegal && out_value == $past(dest_old) && $stable({out_n, out_z, out_v, out_c})); // R8

  AST_LONG_IMM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && src_is_imm && op_sel != LOP_NOT && size_code == SZ_LONG |=> out_pc_step == 3'd4); // R7

  AST_NOT_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op_sel == LOP_NOT |=> out_pc_step == 3'd0); // R10

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_valid == $past(in_valid)); // R1
endmodule

// File: tb/test_sized_logic_unit.sv
`timescale 1ns/1ps
module test_sized_logic_unit;
  localparam int CYC_W = 8;
  localparam int PEN_W = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [1:0]       op_sel = '0;
  logic [1:0]       size_code = '0;
  logic             dst_is_mem = 1'b0;
  logic             src_is_imm = 1'b0;
  logic [31:0]      dest_old = '0;
  logic [31:0]      src_val = '0;
  logic [PEN_W-1:0] ea_penalty = '0;
  logic             flag_x_in = 1'b0;
  logic             out_valid, out_n, out_z, out_v, out_c, out_x, out_illegal;
  logic [31:0]      out_value;
  logic [CYC_W-1:0] out_cycles;
  logic [2:0]       out_pc_step;

  int checks = 0;
  int errors = 0;
  logic exp_n = 1'b0, exp_z = 1'b0;

  always #2.5 clk = ~clk;

  sized_logic_unit #(.CYC_W(CYC_W), .PEN_W(PEN_W)) i_sized_logic_unit (
    .clk, .rst_n, .in_valid, .op_sel, .size_code, .dst_is_mem, .src_is_imm,
    .dest_old, .src_val, .ea_penalty, .flag_x_in,
    .out_valid, .out_value, .out_n, .out_z, .out_v, .out_c, .out_x,
    .out_cycles, .out_pc_step, .out_illegal
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8080_8080;
      3: return 32'h1234_5678;
      4: return 32'h7FFF_00FF;
      5: return 32'h0000_0080;
      6: return 32'hFFFF_0000;
      default: return 32'hA5A5_5A5A;
    endcase
  endfunction

  // Apply one operation, then check the registered results one cycle later.
  task automatic run_op(input logic [1:0] op, input logic [1:0] sz, input logic mem,
                        input logic imm, input logic [31:0] d, input logic [31:0] s,
                        input logic [PEN_W-1:0] pen, input logic x);
    logic [31:0] raw, mask, ev;
    int base;
    logic [2:0] step;
    logic [CYC_W-1:0] cyc;
    in_valid = 1'b1; op_sel = op; size_code = sz; dst_is_mem = mem;
    src_is_imm = imm; dest_old = d; src_val = s; ea_penalty = pen; flag_x_in = x;
    @(negedge clk);
    chk("R1", "valid", {31'd0, out_valid}, 32'd1);
    chk("R9", "x", {31'd0, out_x}, {31'd0, x});
    if (sz == 2'd3) begin
      chk("R8", "illegal", {31'd0, out_illegal}, 32'd1);
      chk("R8", "value", out_value, d);
      chk("R8", "nzvc", {28'd0, out_n, out_z, out_v, out_c}, {28'd0, exp_n, exp_z, 2'b00});
      chk("R8", "cycles", {24'd0, out_cycles}, 32'd0);
      chk("R8", "pcstep", {29'd0, out_pc_step}, 32'd0);
      return;
    end
    mask = (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    case (op)
      2'd0: raw = d & s;
      2'd1: raw = d | s;
      2'd2: raw = d ^ s;
      default: raw = ~d;
    endcase
    ev = (d & ~mask) | (raw & mask);
    exp_n = |(raw & mask & ~(mask >> 1));
    exp_z = ((raw & mask) == 32'd0);
    chk("R1", "value-low", out_value & mask, raw & mask);
    chk("R5", "value-upper", out_value & ~mask, d & ~mask);
    chk("R2", "n", {31'd0, out_n}, {31'd0, exp_n});
    chk("R2", "z", {31'd0, out_z}, {31'd0, exp_z});
    chk("R3", "vc", {30'd0, out_v, out_c}, 32'd0);
    chk("R8", "legal", {31'd0, out_illegal}, 32'd0);
    if (imm && op != 2'd3) begin
      if (op == 2'd0) base = mem ? 12 : 8;
      else base = (sz == 2'd2) ? (mem ? 20 : 16) : (mem ? 12 : 8);
      step = (sz == 2'd2) ? 3'd4 : 3'd2;
      cyc = CYC_W'(base + (mem ? int'(pen) : 0));
      chk("R6", "cycles-imm", {24'd0, out_cycles}, {24'd0, cyc});
      chk("R7", "pcstep-imm", {29'd0, out_pc_step}, {29'd0, step});
    end else begin
      base = (mem ? 8 : 4) + ((sz == 2'd2) ? 4 : 0);
      cyc = CYC_W'(base + (mem ? int'(pen) : 0));
      chk(op == 2'd3 ? "R10" : "R4", "cycles", {24'd0, out_cycles}, {24'd0, cyc});
      chk(op == 2'd3 ? "R10" : "R7", "pcstep", {29'd0, out_pc_step}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "reset-valid", {31'd0, out_valid}, 32'd0);
    chk("R11", "reset-value", out_value, 32'd0);
    chk("R11", "reset-flags", {27'd0, out_n, out_z, out_v, out_c, out_x}, 32'd0);
    chk("R11", "reset-cost", {21'd0, out_cycles, out_pc_step, out_illegal}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int cfg = 0; cfg < 64; cfg++) begin
          run_op(cfg[1:0], cfg[3:2], cfg[4], cfg[5], pat(i), pat(j),
                 PEN_W'((i * 7 + j * 3 + cfg) % 64), cfg[0] ^ i[0]);
        end
      end
    end
    // R8: illegal size right after an op that left N set
    run_op(2'd1, 2'd0, 1'b0, 1'b0, 32'h0000_0080, 32'h0, 6'd0, 1'b1);
    run_op(2'd2, 2'd3, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'h0000_FFFF, 6'd9, 1'b0);
    // R8: illegal size right after an op that left Z set
    run_op(2'd0, 2'd1, 1'b0, 1'b0, 32'hFFFF_00FF, 32'h0000_FF00, 6'd0, 1'b0);
    run_op(2'd3, 2'd3, 1'b0, 1'b0, 32'h0000_0000, 32'h0, 6'd0, 1'b1);
    // R11: idle cycles hold outputs
    in_valid = 1'b0;
    dest_old = 32'h5555_5555;
    size_code = 2'd2;
    @(negedge clk);
    chk("R11", "idle-valid", {31'd0, out_valid}, 32'd0);
    chk("R11", "idle-value", out_value, 32'h0000_0000);
    chk("R11", "idle-z", {31'd0, out_z}, 32'd1);
    chk("R11", "idle-illegal", {31'd0, out_illegal}, 32'd1);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule